// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register file of a serial port. It sits on a simple single-cycle bus inside a 1 KiB address window and presents seven 32-bit word registers: a status word, a data word, a rate word, three control words and a guard word. Received bytes come in on a valid/ready byte stream. Transmitted bytes leave on a one-cycle valid pulse with an 8-bit data bus, and the receiver of that pulse is treated as always ready. Bit-level serialization, baud generation, parity and framing live elsewhere. The rate word, the second and third control words and the guard word are only stored and read back.

The block keeps three status flags: receive-full (status bit 5), transmit-done (status bit 6) and transmit-idle (status bit 7). It drives one level interrupt from the receive path. While a received byte waits in the single holding register, the block applies backpressure to the incoming stream. Software drains the holding register by reading the data word. Software sends a byte by writing the data word. Status writes have two modes: a small value replaces the status word, and a large value clears bits.

Top module: `sio_regfront`

## Requirements
- R1: `rx_ready` is high exactly while the receive-full flag (status bit 5) is clear. An offered byte is taken only on a cycle where `rx_valid` and `rx_ready` are both high.
- R2: A taken byte is dropped, leaving the data word and every flag unchanged, unless control word A (offset 0x0C) has both its port-enable bit 13 and its receive-enable bit 2 set.
- R3: A taken byte that is not dropped is stored in the data word and sets receive-full. The interrupt rises on the same edge if control word A bit 5 (receive interrupt enable) is set. A byte taken in the same cycle as a bus access is applied after that access.
- R4: A read of the data word (offset 0x04) returns the last stored byte, zero-extended and limited to bits 9:0. The read clears receive-full and drops the interrupt.
- R5: A write to the status word (offset 0x00) with a value of at most 0x3FF replaces the status word with that value, with bit 7 forced to 1. A write with a larger value is ANDed into the current status word.
- R6: After any status write, the interrupt is low if receive-full ended up clear. A status write never raises the interrupt.
- R7: A write to the data word with a value below 0xF000 produces a one-cycle `tx_valid` pulse on the next cycle, with `tx_data` equal to the low byte of the value, and sets transmit-done (status bit 6). A data write of 0xF000 or more has no effect.
- R8: A write to control word A stores the value. If the written value has bit 5 set while receive-full is already set, the interrupt rises.
- R9: After reset, the status word reads 0xC0, all other words read 0, `irq` is low and `tx_valid` is low.
- R10: The rate word (0x08), control words B (0x10) and C (0x14) and the guard word (0x18) store all 32 bits and read them back. A read of any other offset, including a misaligned address (bits 1:0 not zero), returns 0, and a write there has no effect. Read data appears on `bus_rdata` one cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | One-cycle transmit pulse |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
A wrong status word shows at the ports on the next cycle. A stuck receive-full flag holds `rx_ready` low and stalls the input stream. A lost flag lets a second byte overwrite the first, which the next data read exposes. Interrupt bugs appear on `irq` one edge after the bus access or byte that should have moved it. The bench therefore checks `irq` and `rx_ready` right after each access, and reads the status word back after each mode of status write. Transmit bugs appear as a missing, extra or wrong `tx_valid` pulse one cycle after the data write, and the transmit monitor catches these against its expected queue.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_REGS  = 7;
    localparam int NUM_STORE = 5;

    // Word selectors; the encoding equals the word index (byte offset / 4).
    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_RATE  = 3'd2,
        SEL_CTLA  = 3'd3,
        SEL_CTLB  = 3'd4,
        SEL_CTLC  = 3'd5,
        SEL_GUARD = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    // Status flag positions
    localparam int FLG_RXFULL = 5;
    localparam int FLG_TXDONE = 6;
    localparam int FLG_TXIDLE = 7;

    // Control word A bit positions
    localparam int CA_RXEN = 2;
    localparam int CA_RXIE = 5;
    localparam int CA_PORTEN = 13;

    localparam logic [REG_W-1:0] STAT_INIT    = 32'h0000_00C0;
    localparam logic [REG_W-1:0] STAT_SET_MAX = 32'h0000_03FF;
    localparam logic [REG_W-1:0] TX_LIMIT     = 32'h0000_F000;
    localparam logic [REG_W-1:0] DATA_VIEW    = 32'h0000_03FF;

    // Plain stored words, index = slot in the storage array
    localparam reg_sel_e STORE_SEL [NUM_STORE] =
        '{SEL_RATE, SEL_CTLA, SEL_CTLB, SEL_CTLC, SEL_GUARD};
    localparam int CTLA_SLOT = 1;

    function automatic logic [REG_W-1:0] data_word(input logic [7:0] b);
        return REG_W'(b) & DATA_VIEW;
    endfunction

endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
    import sio_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output bus_op_t           op
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    always_comb begin
        idx     = acc_addr[ADDR_W-1:2];
        aligned = (acc_addr[1:0] == 2'b00);
        op.rd   = acc_en && !acc_we;
        op.wr   = acc_en && acc_we;
        op.sel  = SEL_NONE;
        if (aligned) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (idx == IDX_W'(i)) op.sel = reg_sel_e'(3'(i));
            end
        end
    end
endmodule

// File: rtl/sio_rx_path.sv
module sio_rx_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_full,
    input  logic              port_on,
    input  logic              recv_on,
    output logic              rx_ready,
    output logic              rx_store,
    output logic [BYTE_W-1:0] hold_q
);
    logic take;

    always_comb begin
        rx_ready = !rx_full;
        take     = rx_valid && rx_ready;
        rx_store = take && port_on && recv_on;
    end

    always_ff @(posedge clk) begin
        if (rst)           hold_q <= '0;
        else if (rx_store) hold_q <= rx_data;
    end

    // R2: a byte taken while the receiver is gated off leaves the holding register alone
    assert_drop_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (take && !(port_on && recv_on)) |=> $stable(hold_q));

    // R3: a stored byte lands in the holding register
    assert_store_byte_R3: assert property (@(posedge clk) disable iff (rst)
        rx_store |=> (hold_q == $past(rx_data)));
endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path
    import sio_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [REG_W-1:0]  wdata,
    output logic              tx_fire,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    logic data_wr;

    always_comb begin
        data_wr = op.wr && (op.sel == SEL_DATA);
        tx_fire = data_wr && (wdata < TX_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire) tx_data <= wdata[BYTE_W-1:0];
        end
    end

    // R7: accepted data write yields a pulse carrying the low byte
    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        tx_fire |=> (tx_valid && tx_data == $past(wdata[BYTE_W-1:0])));

    // R7: high-valued data writes send nothing
    assert_tx_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (data_wr && wdata >= TX_LIMIT) |=> !tx_valid);
endmodule

// File: rtl/sio_status.sv
module sio_status
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_store,
    input  logic             rxie_now,
    input  logic             tx_fire,
    output logic [REG_W-1:0] stat_q,
    output logic             irq_q
);
    logic             stat_wr, data_rd, ctla_wr;
    logic [REG_W-1:0] bus_stat, stat_d;
    logic             irq_d;

    always_comb begin
        stat_wr = op.wr && (op.sel == SEL_STAT);
        data_rd = op.rd && (op.sel == SEL_DATA);
        ctla_wr = op.wr && (op.sel == SEL_CTLA);

        // bus-side effects first
        bus_stat = stat_q;
        if (stat_wr) begin
            if (wdata <= STAT_SET_MAX) begin
                bus_stat = wdata;
                bus_stat[FLG_TXIDLE] = 1'b1;
            end else begin
                bus_stat = stat_q & wdata;
            end
        end
        if (data_rd) bus_stat[FLG_RXFULL] = 1'b0;
        if (tx_fire) bus_stat[FLG_TXDONE] = 1'b1;

        irq_d = irq_q;
        if (data_rd) irq_d = 1'b0;
        if (stat_wr && !bus_stat[FLG_RXFULL]) irq_d = 1'b0;
        if (ctla_wr && wdata[CA_RXIE] && stat_q[FLG_RXFULL]) irq_d = 1'b1;

        // receive side applied after the bus access
        stat_d = bus_stat;
        if (rx_store) begin
            stat_d[FLG_RXFULL] = 1'b1;
            if (rxie_now) irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_INIT;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= irq_d;
        end
    end

    assert_rx_irq_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_store && rxie_now) |=> (irq_q && stat_q[FLG_RXFULL]));

    assert_data_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_store) |=> (!stat_q[FLG_RXFULL] && !irq_q));

    assert_replace_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata <= STAT_SET_MAX) |=> stat_q[FLG_TXIDLE]);

    assert_and_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata > STAT_SET_MAX && !rx_store) |=> ((stat_q & ~$past(wdata)) == '0));

    assert_irq_low_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !rx_store) |=> (stat_q[FLG_RXFULL] || !irq_q));

    assert_no_raise_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !rx_store && !irq_q) |=> !irq_q);

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (rst)
        tx_fire |=> stat_q[FLG_TXDONE]);

    assert_ctla_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (ctla_wr && wdata[CA_RXIE] && stat_q[FLG_RXFULL]) |=> irq_q);
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
    import sio_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    bus_op_t          op;
    logic [REG_W-1:0] store_q [NUM_STORE];
    logic [REG_W-1:0] stat_q;
    logic [BYTE_W-1:0] hold_q;
    logic             rx_store, tx_fire, rx_on;
    logic [REG_W-1:0] rd_mux;

    sio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .acc_en(bus_en), .acc_we(bus_we), .acc_addr(bus_addr), .op(op)
    );

    // Plain stored words
    for (genvar k = 0; k < NUM_STORE; k++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst) store_q[k] <= '0;
            else if (op.wr && op.sel == STORE_SEL[k]) store_q[k] <= bus_wdata;
        end
    end

    assign rx_on = store_q[CTLA_SLOT][CA_PORTEN] && store_q[CTLA_SLOT][CA_RXEN];

    sio_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_full(stat_q[FLG_RXFULL]),
        .port_on(store_q[CTLA_SLOT][CA_PORTEN]),
        .recv_on(store_q[CTLA_SLOT][CA_RXEN]),
        .rx_ready(rx_ready), .rx_store(rx_store), .hold_q(hold_q)
    );

    sio_tx_path #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst(rst), .op(op), .wdata(bus_wdata),
        .tx_fire(tx_fire), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    sio_status u_stat (
        .clk(clk), .rst(rst), .op(op), .wdata(bus_wdata),
        .rx_store(rx_store), .rxie_now(store_q[CTLA_SLOT][CA_RXIE]),
        .tx_fire(tx_fire), .stat_q(stat_q), .irq_q(irq)
    );

    always_comb begin
        rd_mux = '0;
        if (op.sel == SEL_STAT) rd_mux = stat_q;
        if (op.sel == SEL_DATA) rd_mux = data_word(8'(hold_q));
        for (int k = 0; k < NUM_STORE; k++) begin
            if (op.sel == STORE_SEL[k]) rd_mux = store_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (op.rd) bus_rdata <= rd_mux;
    end

    // R1: taking an enabled byte closes the input on the next cycle
    assert_ready_drops_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && rx_on) |=> !rx_ready);

    // R10: reads of unmapped or misaligned addresses return zero
    assert_undef_read_R10: assert property (@(posedge clk) disable iff (rst)
        (op.rd && op.sel == SEL_NONE) |=> (bus_rdata == '0));

    // R10: read data holds between reads
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !op.rd |=> $stable(bus_rdata));
endmodule

// File: tb/sio_regfront_tb.sv
module sio_regfront_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] tx_exp_q [$];

    always #2 clk = ~clk;

    sio_regfront u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == 10'h004 && d < 32'hF000) tx_exp_q.push_back(d[7:0]);
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Scoreboard monitor for the transmit stream (R7)
    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            if (tx_exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 actual=unexpected tx 0x%02h expected=no pulse", tx_data);
            end else begin
                check("R7 tx byte", 32'(tx_data), 32'(tx_exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 irq", 32'(irq), 0);
        rst = 1'b0;
        check("R9 tx_valid", 32'(tx_valid), 0);
        check("R1 ready at reset", 32'(rx_ready), 1);
        rd(10'h000, 32'hC0, "R9 status");
        rd(10'h00C, 32'h0, "R9 ctl A");
        rd(10'h008, 32'h0, "R9 rate");
        rd(10'h004, 32'h0, "R9 data");

        // R2: receiver gated off
        rx_send(8'h5A);
        check("R2 ready", 32'(rx_ready), 1);
        check("R2 irq", 32'(irq), 0);
        rd(10'h000, 32'hC0, "R2 status");
        rd(10'h004, 32'h0, "R2 data");

        // R3 / R1: enabled with interrupt
        wr(10'h00C, 32'h2024);
        rd(10'h00C, 32'h2024, "R8 ctl A store");
        check("R8 irq no full", 32'(irq), 0);
        rx_send(8'hA5);
        check("R1 ready low", 32'(rx_ready), 0);
        check("R3 irq", 32'(irq), 1);
        rd(10'h000, 32'hE0, "R3 status");
        rx_send(8'h33);
        rd(10'h004, 32'hA5, "R1 backpressure keeps byte");
        check("R4 irq", 32'(irq), 0);
        check("R4 ready", 32'(rx_ready), 1);
        rd(10'h000, 32'hC0, "R4 status");

        // R3 without interrupt, R8 raise
        wr(10'h00C, 32'h2004);
        rx_send(8'h3C);
        check("R3 irq masked", 32'(irq), 0);
        check("R1 ready", 32'(rx_ready), 0);
        wr(10'h00C, 32'h2024);
        check("R8 raise", 32'(irq), 1);

        // R5 / R6 replace mode
        wr(10'h000, 32'h0);
        check("R6 irq drop", 32'(irq), 0);
        check("R1 ready after clear", 32'(rx_ready), 1);
        rd(10'h000, 32'h80, "R5 replace");
        rd(10'h004, 32'h3C, "R4 data");

        // R7 transmit
        wr(10'h004, 32'h141);
        rd(10'h000, 32'hC0, "R7 done flag");

        // R5 AND mode
        wr(10'h000, 32'hFFFF_FFBF);
        rd(10'h000, 32'h80, "R5 and");
        wr(10'h000, 32'h400);
        rd(10'h000, 32'h0, "R5 and zero");
        wr(10'h000, 32'h3FF);
        rd(10'h000, 32'h3FF, "R5 replace max");
        check("R1 ready sw full", 32'(rx_ready), 0);
        check("R6 no raise", 32'(irq), 0);
        wr(10'h000, 32'h20);
        rd(10'h000, 32'hA0, "R5 replace small");
        rd(10'h004, 32'h3C, "R4 data again");
        check("R4 ready", 32'(rx_ready), 1);
        rd(10'h000, 32'h80, "R4 status");

        // R7 limit
        wr(10'h004, 32'hF000);
        rd(10'h000, 32'h80, "R7 ignored");
        wr(10'h004, 32'hEFFF);
        rd(10'h000, 32'hC0, "R7 edge");

        // R10 stored words and undefined offsets
        wr(10'h008, 32'h1234_5678);
        wr(10'h010, 32'hCAFE_0001);
        wr(10'h014, 32'h0000_BEEF);
        wr(10'h018, 32'hFFFF_FFFF);
        rd(10'h008, 32'h1234_5678, "R10 rate");
        rd(10'h010, 32'hCAFE_0001, "R10 ctl B");
        rd(10'h014, 32'h0000_BEEF, "R10 ctl C");
        rd(10'h018, 32'hFFFF_FFFF, "R10 guard");
        wr(10'h01C, 32'h55);
        rd(10'h01C, 32'h0, "R10 undefined");
        wr(10'h00A, 32'h0);
        rd(10'h008, 32'h1234_5678, "R10 misaligned write");
        rd(10'h009, 32'h0, "R10 misaligned read");
        rd(10'h3FC, 32'h0, "R10 top");
        rd(10'h000, 32'hC0, "R10 status untouched");

        // R9 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 irq", 32'(irq), 0);
        rd(10'h000, 32'hC0, "R9 status");
        rd(10'h00C, 32'h0, "R9 ctl A");
        rd(10'h018, 32'h0, "R9 guard");

        repeat (3) @(negedge clk);
        check("R7 queue drained", 32'(tx_exp_q.size()), 0);
        finish_run();
    end
endmodule